// File: doc/BRIEF.md
# Triggered Waveform Window Decimator

This block sits behind one channel of a 14-bit converter that delivers an unsigned sample every 25 ns. In its normal mode it reduces the stream by a factor of 16 with a boxcar average, giving one value every 400 ns. It keeps every reduced value in a circular history. When an external trigger is accepted, it sends out a window of reduced values. The window holds a fixed number of values from before the trigger and a fixed number from after it. With the default depth of 10000 on each side, this spans about 4 ms on each side of the trigger. The default parameters are smaller so that elaboration stays light.

A configuration input selects raw mode for special runs. In raw mode every 25 ns sample is stored and sent without averaging. The mode input is only applied while no window is in progress. A switch clears the history, so a window never mixes the two kinds of sample.

The output is a valid/ready stream. Each beat carries a first-of-window marker, a last-of-window marker and a short-history flag. A 16-bit counter records triggers that were dropped because a window was already in progress. The consumer must accept beats at least as fast as new history values are written once the trigger window has been filled. Otherwise the writer laps the values still waiting to be read.

Top module: `trig_window_decimator`

## Requirements
- R1: In decimated mode, every 16 accepted input samples produce one stored value equal to their sum divided by 16, rounded down. A full-scale input of 16383 therefore yields 16383.
- R2: In raw mode, every accepted input sample is stored unchanged as one value.
- R3: An accepted trigger produces a window of PRE_DEPTH values written before the trigger cycle, followed by POST_DEPTH values written from the trigger cycle onward. A value written in the trigger cycle itself is the first post-trigger value.
- R4: If fewer than PRE_DEPTH values have been stored since reset or since the last mode switch, the window starts at the oldest stored value, and out_short is 1 on every beat of that window.
- R5: out_sow is 1 on the first beat of a window only, and out_eow is 1 on the last beat only. After the last beat is accepted, the block is ready for a new trigger.
- R6: While out_valid is 1 and out_ready is 0, out_valid, out_data, out_sow and out_eow hold their values.
- R7: A trigger that arrives while a window is in progress has no effect on the window. It increments ovf_count, which saturates at 65535.
- R8: A change of raw_mode_cfg (0 = decimated, 1 = raw) takes effect on the first cycle in which no window is in progress and trig_in is 0. That switch empties the history and drops any partial average.
- R9: After reset, out_valid is 0, ovf_count is 0, and the block is in decimated mode with an empty history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one input sample slot per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample present this cycle |
| in_data | input | 14 | Unsigned converter code |
| trig_in | input | 1 | External trigger, sampled each cycle |
| raw_mode_cfg | input | 1 | Requested mode: 0 decimated, 1 raw |
| out_valid | output | 1 | Window beat available |
| out_ready | input | 1 | Consumer accepts the beat |
| out_data | output | 14 | Window value |
| out_sow | output | 1 | First beat of a window |
| out_eow | output | 1 | Last beat of a window |
| out_short | output | 1 | Window began with less than full history |
| ovf_count | output | 16 | Saturating count of dropped triggers |

## Verification
Saturating the dropped-trigger counter is the hardest case to reach from the ports, because it needs tens of thousands of triggers to land inside one window. The stimulus holds the window open: it stops the input stream so that no post-trigger values arrive, holds out_ready low, and keeps trig_in high for more than 65535 cycles. It then releases the stream and checks the window contents. A second hard case is a mode request made during a window, because the switch must wait for the final handshake. The bench sees that handshake on the output, idles the input around it, and places its own history reset on the exact switch cycle.

// File: rtl/twd_pkg.sv
package twd_pkg;

  localparam int SMP_W = 14;

  typedef logic [SMP_W-1:0] smp_t;

  // Boxcar mean: drop the low bits of an accumulated total.
  function automatic smp_t box_mean(logic [31:0] total, int sh);
    logic [31:0] q;
    q = total >> sh;
    return q[SMP_W-1:0];
  endfunction

  // Pointer moved back by a distance on a ring of the given depth.
  function automatic int ring_back(int p, int d, int depth);
    int r;
    r = p - d;
    if (r < 0) r = r + depth;
    return r;
  endfunction

  // Pointer moved forward by one on a ring of the given depth.
  function automatic int ring_next(int p, int depth);
    return (p + 1 == depth) ? 0 : p + 1;
  endfunction

endpackage

// File: rtl/twd_decimator.sv
module twd_decimator
  import twd_pkg::*;
#(
  parameter int DEC_LOG2 = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic raw,
  input  logic in_valid,
  input  smp_t in_data,
  output logic smp_valid,
  output smp_t smp_data
);

  localparam int RATIO = 1 << DEC_LOG2;
  localparam int ACC_W = SMP_W + DEC_LOG2;

  logic [DEC_LOG2-1:0] phase;
  logic [ACC_W-1:0]    acc;
  logic                phase_last;

  assign phase_last = (phase == DEC_LOG2'(RATIO - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase     <= '0;
      acc       <= '0;
      smp_valid <= 1'b0;
      smp_data  <= '0;
    end else if (restart) begin
      phase     <= '0;
      acc       <= '0;
      smp_valid <= 1'b0;
    end else begin
      smp_valid <= 1'b0;
      if (in_valid) begin
        if (raw) begin
          smp_valid <= 1'b1;
          smp_data  <= in_data;
        end else if (phase_last) begin
          smp_valid <= 1'b1;
          smp_data  <= box_mean(32'(acc) + 32'(in_data), DEC_LOG2);
          acc       <= '0;
          phase     <= '0;
        end else begin
          acc   <= acc + ACC_W'(in_data);
          phase <= phase + 1'b1;
        end
      end
    end
  end

  // A decimated value leaves only when the phase has just wrapped.
  assert_phase_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && !raw) |-> (phase == '0))
    else $error("decimated value emitted off phase boundary");

endmodule

// File: rtl/twd_history.sv
module twd_history
  import twd_pkg::*;
#(
  parameter int PRE   = 4,
  parameter int DEPTH = 8,
  parameter int AW    = 3,
  parameter int FW    = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          wr_valid,
  input  smp_t          wr_data,
  input  logic [AW-1:0] rd_ptr,
  output logic          wr_fire,
  output logic [AW-1:0] wr_ptr,
  output logic [FW-1:0] fill,
  output smp_t          rd_data
);

  smp_t mem [DEPTH];

  assign wr_fire = wr_valid && !clear;
  assign rd_data = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (wr_fire) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      fill   <= '0;
    end else if (clear) begin
      fill <= '0;
    end else if (wr_fire) begin
      wr_ptr <= AW'(ring_next(int'(wr_ptr), DEPTH));
      if (fill < FW'(PRE)) fill <= fill + 1'b1;
    end
  end

  assert_fill_cap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= FW'(PRE))
    else $error("history fill beyond pre-trigger depth");

  assert_clear_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (fill == '0))
    else $error("history not emptied by mode switch");

endmodule

// File: rtl/twd_window.sv
module twd_window
  import twd_pkg::*;
#(
  parameter int PRE   = 4,
  parameter int POST  = 3,
  parameter int DEPTH = 8,
  parameter int AW    = 3,
  parameter int FW    = 3,
  parameter int CW    = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          trig,
  input  logic          wr_fire,
  input  logic [AW-1:0] wr_ptr,
  input  logic [FW-1:0] fill,
  input  logic          out_ready,
  output logic [AW-1:0] rd_ptr,
  output logic          win_active,
  output logic          out_valid,
  output logic          out_sow,
  output logic          out_eow,
  output logic          out_short,
  output logic [15:0]   ovf_count
);

  logic [CW-1:0] avail;
  logic [CW-1:0] post_left;
  logic          first_q;
  logic          short_q;

  // Named events for the assertions.
  logic trig_take, trig_drop, hs, post_fire;

  assign trig_take = trig && !win_active;
  assign trig_drop = trig && win_active;
  assign post_fire = wr_fire && (post_left != '0);
  assign out_valid = win_active && (avail != '0);
  assign hs        = out_valid && out_ready;
  assign out_eow   = out_valid && (avail == CW'(1)) && (post_left == '0);
  assign out_sow   = out_valid && first_q;
  assign out_short = out_valid && short_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr     <= '0;
      win_active <= 1'b0;
      avail      <= '0;
      post_left  <= '0;
      first_q    <= 1'b0;
      short_q    <= 1'b0;
      ovf_count  <= '0;
    end else begin
      if (trig_take) begin
        win_active <= 1'b1;
        rd_ptr     <= AW'(ring_back(int'(wr_ptr), int'(fill), DEPTH));
        avail      <= CW'(fill) + CW'(wr_fire);
        post_left  <= CW'(POST) - CW'(wr_fire);
        first_q    <= 1'b1;
        short_q    <= (fill < FW'(PRE));
      end else if (win_active) begin
        avail <= avail + CW'(post_fire) - CW'(hs);
        if (post_fire) post_left <= post_left - CW'(1);
        if (hs) begin
          rd_ptr  <= AW'(ring_next(int'(rd_ptr), DEPTH));
          first_q <= 1'b0;
          if (out_eow) win_active <= 1'b0;
        end
      end
      if (trig_drop && (ovf_count != 16'hFFFF)) ovf_count <= ovf_count + 16'd1;
    end
  end

  assert_avail_cap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    win_active |-> (avail <= CW'(PRE + POST)))
    else $error("more pending beats than a window holds");

  assert_eow_closes_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (hs && out_eow) |=> !win_active)
    else $error("window still open after last beat");

  assert_sow_once_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (hs && out_sow) |=> !out_sow)
    else $error("start marker repeated");

  assert_ovf_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_drop && ovf_count != 16'hFFFF) |=> (ovf_count == $past(ovf_count) + 16'd1))
    else $error("dropped trigger not counted");

  assert_ovf_hold_max_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_count == 16'hFFFF) |=> (ovf_count == 16'hFFFF))
    else $error("overflow counter wrapped");

endmodule

// File: rtl/trig_window_decimator.sv
module trig_window_decimator
  import twd_pkg::*;
#(
  parameter int PRE_DEPTH  = 1000,
  parameter int POST_DEPTH = 1000,
  parameter int DEC_LOG2   = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [13:0] in_data,
  input  logic        trig_in,
  input  logic        raw_mode_cfg,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [13:0] out_data,
  output logic        out_sow,
  output logic        out_eow,
  output logic        out_short,
  output logic [15:0] ovf_count
);

  localparam int DEPTH = PRE_DEPTH + POST_DEPTH + 1;
  localparam int AW    = $clog2(DEPTH);
  localparam int FW    = $clog2(PRE_DEPTH + 1);
  localparam int CW    = $clog2(PRE_DEPTH + POST_DEPTH + 1);

  logic          raw_q;
  logic          mode_switch;
  logic          win_active;
  logic          smp_valid;
  smp_t          smp_data;
  logic          wr_fire;
  logic [AW-1:0] wr_ptr;
  logic [AW-1:0] rd_ptr;
  logic [FW-1:0] fill;
  smp_t          rd_data;

  assign mode_switch = (raw_mode_cfg != raw_q) && !win_active && !trig_in;

  always_ff @(posedge clk) begin
    if (!rst_n)           raw_q <= 1'b0;
    else if (mode_switch) raw_q <= raw_mode_cfg;
  end

  twd_decimator #(.DEC_LOG2(DEC_LOG2)) u_dec (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart   (mode_switch),
    .raw       (raw_q),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .smp_valid (smp_valid),
    .smp_data  (smp_data)
  );

  twd_history #(.PRE(PRE_DEPTH), .DEPTH(DEPTH), .AW(AW), .FW(FW)) u_hist (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (mode_switch),
    .wr_valid (smp_valid),
    .wr_data  (smp_data),
    .rd_ptr   (rd_ptr),
    .wr_fire  (wr_fire),
    .wr_ptr   (wr_ptr),
    .fill     (fill),
    .rd_data  (rd_data)
  );

  twd_window #(.PRE(PRE_DEPTH), .POST(POST_DEPTH), .DEPTH(DEPTH),
               .AW(AW), .FW(FW), .CW(CW)) u_win (
    .clk        (clk),
    .rst_n      (rst_n),
    .trig       (trig_in),
    .wr_fire    (wr_fire),
    .wr_ptr     (wr_ptr),
    .fill       (fill),
    .out_ready  (out_ready),
    .rd_ptr     (rd_ptr),
    .win_active (win_active),
    .out_valid  (out_valid),
    .out_sow    (out_sow),
    .out_eow    (out_eow),
    .out_short  (out_short),
    .ovf_count  (ovf_count)
  );

  assign out_data = rd_data;

  assert_hold_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_data) && $stable(out_sow) && $stable(out_eow)))
    else $error("output changed while stalled");

  assert_mode_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    win_active |=> $stable(raw_q))
    else $error("mode changed inside a window");

endmodule

// File: tb/trig_window_decimator_tb.sv
module trig_window_decimator_tb;

  localparam int CLK_PERIOD = 10;
  localparam int PRE  = 4;
  localparam int POST = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [13:0] in_data = '0;
  logic        trig_in = 1'b0;
  logic        raw_mode_cfg = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [13:0] out_data;
  logic        out_sow, out_eow, out_short;
  logic [15:0] ovf_count;

  trig_window_decimator #(.PRE_DEPTH(PRE), .POST_DEPTH(POST), .DEC_LOG2(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .trig_in(trig_in), .raw_mode_cfg(raw_mode_cfg), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_sow(out_sow),
    .out_eow(out_eow), .out_short(out_short), .ovf_count(ovf_count)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int checks = 0;
  int fails  = 0;

  // Bench model of the stored history.
  int hv [0:4095];
  int hcount = 0, hbase = 0;
  int macc = 0, mph = 0, pend_v = 0, pend_d = 0, mraw = 0;
  int n_in = 0, tick = 0;
  int ready_mode = 0;
  bit use_max = 0;
  int exp_start = 0, exp_n = 0;
  bit exp_short = 0;

  // Collected window.
  int got_d [0:63];
  bit got_s [0:63];
  bit got_e [0:63];
  bit got_sh [0:63];
  int gn = 0;
  bit done = 0;
  bit stall_seen = 0;
  int st_d = 0;
  bit st_s = 0, st_e = 0;
  int stall_checks = 0, stall_bad = 0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [13:0] pat(int n);
    return 14'((n * 421 + 97 + (n / 7) * 1303) % 16384);
  endfunction

  // One clock edge with the given stimulus; the model follows the requirements.
  task automatic step(bit v, bit t, bit t_acc, bit restart, bit new_raw);
    logic [13:0] d;
    d = use_max ? 14'h3FFF : pat(n_in);
    if (v) n_in++;
    in_valid  = v;
    in_data   = d;
    trig_in   = t;
    out_ready = (ready_mode == 0) ? 1'b1 : (ready_mode == 1) ? (tick % 3 != 0) : 1'b0;
    @(posedge clk);
    tick++;
    if (t && t_acc) begin
      exp_short = (hcount - hbase) < PRE;
      exp_start = exp_short ? hbase : hcount - PRE;
      exp_n     = (hcount - exp_start) + POST;
      gn   = 0;
      done = 0;
    end
    if (pend_v != 0 && !restart) begin
      hv[hcount] = pend_d;
      hcount++;
    end
    if (restart) begin
      hbase = hcount; macc = 0; mph = 0; pend_v = 0; mraw = int'(new_raw);
    end else begin
      pend_v = 0;
      if (v) begin
        if (mraw != 0) begin
          pend_v = 1; pend_d = int'(d);
        end else begin
          macc = macc + int'(d);
          mph++;
          if (mph == 16) begin
            pend_v = 1; pend_d = macc / 16; macc = 0; mph = 0;
          end
        end
      end
    end
    #1;
    trig_in = 1'b0;
  endtask

  task automatic feed(int count, bit v);
    for (int i = 0; i < count; i++) step(v, 0, 0, 0, 0);
  endtask

  task automatic run_until_done();
    int g;
    g = 0;
    while (!done && g < 3000) begin
      step(1, 0, 0, 0, 0);
      g++;
    end
  endtask

  task automatic check_win(string dreq);
    bit saw_max;
    saw_max = 0;
    chk(gn == exp_n, "R3", "window length", gn, exp_n);
    for (int i = 0; i < exp_n && i < gn; i++) begin
      chk(got_d[i] == hv[exp_start + i], dreq, "window value", got_d[i], hv[exp_start + i]);
      chk(got_s[i] == (i == 0), "R5", "start marker", int'(got_s[i]), int'(i == 0));
      chk(got_e[i] == (i == exp_n - 1), "R5", "end marker", int'(got_e[i]), int'(i == exp_n - 1));
      chk(got_sh[i] == exp_short, "R4", "short flag", int'(got_sh[i]), int'(exp_short));
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (stall_seen) begin
        stall_checks++;
        if (!out_valid || int'(out_data) != st_d || out_sow != st_s || out_eow != st_e)
          stall_bad++;
      end
      stall_seen = out_valid && !out_ready;
      st_d = int'(out_data); st_s = out_sow; st_e = out_eow;
      if (out_valid && out_ready) begin
        if (gn < 64) begin
          got_d[gn] = int'(out_data); got_s[gn] = out_sow;
          got_e[gn] = out_eow; got_sh[gn] = out_short;
        end
        gn++;
        if (out_eow) done = 1;
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 190000);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", tick, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    bit saw_max;
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    // R9: reset state
    chk(out_valid == 1'b0, "R9", "out_valid after reset", int'(out_valid), 0);
    chk(ovf_count == 16'd0, "R9", "ovf after reset", int'(ovf_count), 0);

    // R1 R3 R4: early trigger with partial history, plus one dropped trigger (R7)
    feed(40, 1);
    step(1, 1, 1, 0, 0);
    chk(exp_short == 1, "R4", "model expects short", int'(exp_short), 1);
    feed(5, 1);
    step(1, 1, 0, 0, 0);
    run_until_done();
    check_win("R1");
    chk(ovf_count == 16'd1, "R7", "dropped trigger count", int'(ovf_count), 1);

    // R1 full scale, R6 stalls, R8 deferred mode request
    ready_mode = 1;
    use_max = 1;
    feed(64, 1);
    use_max = 0;
    feed(16, 1);
    step(1, 1, 1, 0, 0);
    feed(3, 1);
    raw_mode_cfg = 1'b1;
    run_until_done();
    step(0, 0, 0, 1, 1);
    feed(3, 0);
    ready_mode = 0;
    check_win("R8");
    saw_max = 0;
    for (int i = 0; i < gn && i < 64; i++) if (got_d[i] == 16383) saw_max = 1;
    chk(saw_max, "R1", "full-scale average present", int'(saw_max), 1);

    // R2: raw window
    feed(10, 1);
    step(1, 1, 1, 0, 0);
    run_until_done();
    check_win("R2");

    // R8 switch back to decimated empties history; R4 short window
    raw_mode_cfg = 1'b0;
    step(0, 0, 0, 1, 0);
    feed(36, 1);
    step(1, 1, 1, 0, 0);
    chk(exp_short == 1, "R4", "model expects short after switch", int'(exp_short), 1);
    run_until_done();
    check_win("R8");

    // R7 saturation: window held open with input stopped and ready low
    feed(80, 1);
    ready_mode = 2;
    step(0, 1, 1, 0, 0);
    for (int i = 0; i < 65540; i++) step(0, 1, 0, 0, 0);
    chk(ovf_count == 16'hFFFF, "R7", "ovf saturated", int'(ovf_count), 65535);
    chk(gn == 0, "R7", "no beats while stalled", gn, 0);
    ready_mode = 0;
    run_until_done();
    check_win("R3");
    chk(ovf_count == 16'hFFFF, "R7", "ovf stays saturated", int'(ovf_count), 65535);

    chk(stall_checks > 0, "R6", "stall cycles observed", stall_checks, 1);
    chk(stall_bad == 0, "R6", "stalled output changed", stall_bad, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule